// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block supplies operand addresses for indirect data-memory accesses. It contains two independent generator units, so two operands can be addressed in the same cycle. Each unit holds four pointer registers, four step registers and four span registers, plus a hidden window-start register for each pointer. An access picks one pointer and, independently, one step register. The selected pointer goes out as the address in that same cycle. At the next clock edge the pointer advances by the signed step.

When the chosen pointer's span is nonzero, the advance wraps so the pointer stays inside the window that begins at its start register and holds span words. A span of zero gives plain linear stepping over the 14-bit address space. All registers are written through one shared load port. That port names the unit, the register kind and the register number.

Top module: `cdag_top`

## Requirements
- R1: After synchronous reset every pointer, step, span and window-start register of both units is zero, so an access to any pointer returns address 0.
- R2: While `acc_en[g]` is high, `addr` slice g shows the selected pointer's current value in the same cycle and `addr_vld[g]` is high; `addr_vld[g]` is low when `acc_en[g]` is low.
- R3: With span 0, an access replaces the pointer with (pointer + step) modulo 2^14, the step taken as 14-bit two's complement.
- R4: The step register used by an access is chosen by `acc_mod` independently of the pointer chosen by `acc_ptr`; inside the window, the new pointer is the pointer plus that step.
- R5: With span L nonzero, if pointer + step is at or beyond start + L, the new pointer is pointer + step − L.
- R6: With span L nonzero, if pointer + step is below start, the new pointer is pointer + step + L.
- R7: A pointer load (ld_kind 0) also writes the same value into that pointer's window-start register, and later wrapping is relative to it.
- R8: If a pointer load and an access to the same pointer of the same unit fall in one cycle, the address output is the old pointer and the register afterwards holds the loaded value.
- R9: The two units are independent: both may access in one cycle, and a load aimed at one unit (`ld_gen`) leaves the other unchanged.
- R10: In a cycle with no access and no pointer load, every pointer keeps its value.
- R11: Load kinds are 0 pointer, 1 step, 2 span; kind 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe |
| ld_gen | input | 1 | Unit addressed by the load |
| ld_kind | input | 2 | Register kind: 0 pointer, 1 step, 2 span, 3 none |
| ld_sel | input | 2 | Register number within the kind |
| ld_data | input | 14 | Load value |
| acc_en | input | 2 | Access request, one bit per unit |
| acc_ptr | input | 4 | Pointer select, 2 bits per unit (unit 0 in the low bits) |
| acc_mod | input | 4 | Step select, 2 bits per unit |
| addr | output | 28 | Issued address, 14 bits per unit |
| addr_vld | output | 2 | Address valid, one bit per unit |

## Verification
The bench sweeps every pointer against every step register in both units. Spans are zero, five, six and seven, and the steps are positive and negative. Every address is compared with an arithmetic modulo model. An update that mishandled the upper or the lower wrap edge would leave the window or skip a word. Crossing from 16383 to 0 at span zero catches a wrap that is not taken modulo 2^14. A load landing on a pointer in the same cycle as an access would show the stepped value if the priority were reversed. Loads to one unit while the other steps, and idle cycles, would expose crosstalk between units or spurious updates.

// File: rtl/cdag_pkg.sv
package cdag_pkg;
    parameter int ADDR_W  = 14;
    parameter int NREG    = 4;
    parameter int NUM_GEN = 2;
    localparam int SEL_W  = $clog2(NREG);
    localparam int GEN_W  = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;
    localparam int EXT_W  = ADDR_W + 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic signed [EXT_W-1:0] ext_t;

    typedef enum logic [1:0] {
        LD_PTR  = 2'd0,
        LD_STEP = 2'd1,
        LD_SPAN = 2'd2,
        LD_NONE = 2'd3
    } ld_kind_e;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] ptr;
        logic [SEL_W-1:0] step;
    } acc_req_t;

    typedef struct packed {
        logic             en;
        ld_kind_e         kind;
        logic [SEL_W-1:0] sel;
        addr_t            data;
    } ld_req_t;

    function automatic ext_t zext(addr_t v);
        return ext_t'({2'b00, v});
    endfunction

    function automatic ext_t sext(addr_t v);
        return ext_t'({{2{v[ADDR_W-1]}}, v});
    endfunction
endpackage

// File: rtl/cdag_wrap.sv
module cdag_wrap
    import cdag_pkg::*;
(
    input  addr_t ptr,
    input  addr_t step,
    input  addr_t start,
    input  addr_t span,
    output addr_t nxt
);
    ext_t sum;
    ext_t lim;
    ext_t res;

    always_comb begin
        sum = zext(ptr) + sext(step);
        lim = zext(start) + zext(span);
        if (span == '0)
            res = sum;
        else if (sum >= lim)
            res = sum - zext(span);
        else if (sum < zext(start))
            res = sum + zext(span);
        else
            res = sum;
        nxt = res[ADDR_W-1:0];
    end
endmodule

// File: rtl/cdag_unit.sv
module cdag_unit
    import cdag_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ld_req_t  ld,
    input  acc_req_t acc,
    output addr_t    addr,
    output logic     addr_vld
);
    addr_t [NREG-1:0] ptr_q;
    addr_t [NREG-1:0] step_q;
    addr_t [NREG-1:0] span_q;
    addr_t [NREG-1:0] start_q;

    addr_t cur_ptr, cur_step, cur_span, cur_start, nxt_ptr;
    logic  ld_hit;
    logic  ptr_ld;

    assign cur_ptr   = ptr_q[acc.ptr];
    assign cur_step  = step_q[acc.step];
    assign cur_span  = span_q[acc.ptr];
    assign cur_start = start_q[acc.ptr];
    assign ptr_ld    = ld.en && (ld.kind == LD_PTR);
    assign ld_hit    = ptr_ld && (ld.sel == acc.ptr);

    cdag_wrap u_wrap (
        .ptr   (cur_ptr),
        .step  (cur_step),
        .start (cur_start),
        .span  (cur_span),
        .nxt   (nxt_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            step_q  <= '0;
            span_q  <= '0;
            start_q <= '0;
        end else begin
            if (acc.en)
                ptr_q[acc.ptr] <= nxt_ptr;
            if (ld.en) begin
                unique case (ld.kind)
                    LD_PTR: begin
                        ptr_q[ld.sel]   <= ld.data;
                        start_q[ld.sel] <= ld.data;
                    end
                    LD_STEP: step_q[ld.sel] <= ld.data;
                    LD_SPAN: span_q[ld.sel] <= ld.data;
                    default: ;
                endcase
            end
        end
    end

    assign addr     = cur_ptr;
    assign addr_vld = acc.en;

    logic [ADDR_W:0] step_mag;
    logic            in_window;
    assign step_mag  = cur_step[ADDR_W-1] ? ({1'b0, ~cur_step} + 1'b1) : {1'b0, cur_step};
    assign in_window = (cur_ptr >= cur_start) &&
                       ({1'b0, cur_ptr} < ({1'b0, cur_start} + {1'b0, cur_span}));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.en && cur_span == '0 && !ld_hit) |=>
        ptr_q[$past(acc.ptr)] == addr_t'($past(cur_ptr) + $past(cur_step)));

    // R5 R6
    window_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.en && cur_span != '0 && !ld_hit && in_window && step_mag < {1'b0, cur_span}) |=>
        (ptr_q[$past(acc.ptr)] >= $past(cur_start)) &&
        ({1'b0, ptr_q[$past(acc.ptr)]} < ({1'b0, $past(cur_start)} + {1'b0, $past(cur_span)})));

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_ld |=> ptr_q[$past(ld.sel)] == $past(ld.data));

    // R7
    start_latch_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_ld |=> start_q[$past(ld.sel)] == $past(ld.data));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc.en && !ptr_ld) |=> $stable(ptr_q));
endmodule

// File: rtl/cdag_top.sv
module cdag_top
    import cdag_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ld_en,
    input  logic [GEN_W-1:0]          ld_gen,
    input  logic [1:0]                ld_kind,
    input  logic [SEL_W-1:0]          ld_sel,
    input  logic [ADDR_W-1:0]         ld_data,
    input  logic [NUM_GEN-1:0]        acc_en,
    input  logic [NUM_GEN*SEL_W-1:0]  acc_ptr,
    input  logic [NUM_GEN*SEL_W-1:0]  acc_mod,
    output logic [NUM_GEN*ADDR_W-1:0] addr,
    output logic [NUM_GEN-1:0]        addr_vld
);
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_unit
        ld_req_t  ld_g;
        acc_req_t acc_g;
        addr_t    addr_g;

        assign ld_g.en    = ld_en && (ld_gen == GEN_W'(g));
        assign ld_g.kind  = ld_kind_e'(ld_kind);
        assign ld_g.sel   = ld_sel;
        assign ld_g.data  = ld_data;
        assign acc_g.en   = acc_en[g];
        assign acc_g.ptr  = acc_ptr[g*SEL_W +: SEL_W];
        assign acc_g.step = acc_mod[g*SEL_W +: SEL_W];

        cdag_unit u_unit (
            .clk      (clk),
            .rst      (rst),
            .ld       (ld_g),
            .acc      (acc_g),
            .addr     (addr_g),
            .addr_vld (addr_vld[g])
        );

        assign addr[g*ADDR_W +: ADDR_W] = addr_g;
    end
endmodule

// File: tb/tb_cdag_top.sv
module tb_cdag_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [0:0]  ld_gen = '0;
    logic [1:0]  ld_kind = '0;
    logic [1:0]  ld_sel = '0;
    logic [13:0] ld_data = '0;
    logic [1:0]  acc_en = '0;
    logic [3:0]  acc_ptr = '0;
    logic [3:0]  acc_mod = '0;
    logic [27:0] addr;
    logic [1:0]  addr_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_ptr  [2][4];
    int m_step [2][4];
    int m_span [2][4];
    int m_start[2][4];

    always #10 clk = ~clk;

    cdag_top dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_gen(ld_gen), .ld_kind(ld_kind),
        .ld_sel(ld_sel), .ld_data(ld_data), .acc_en(acc_en), .acc_ptr(acc_ptr),
        .acc_mod(acc_mod), .addr(addr), .addr_vld(addr_vld)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int raw_off(int g, int p, int s);
        return m_ptr[g][p] - m_start[g][p] + m_step[g][s];
    endfunction

    function automatic int model_next(int g, int p, int s);
        int l = m_span[g][p];
        int o;
        if (l == 0) return (m_ptr[g][p] + m_step[g][s]) & 16383;
        o = raw_off(g, p, s);
        o = ((o % l) + l) % l;
        return m_start[g][p] + o;
    endfunction

    function automatic string auto_tag(int g, int p, int s);
        int o;
        if (m_span[g][p] == 0) return "R3";
        o = raw_off(g, p, s);
        if (o >= m_span[g][p]) return "R5";
        if (o < 0) return "R6";
        return "R4";
    endfunction

    task automatic load(int g, int k, int s, int v);
        ld_en = 1'b1; ld_gen = 1'(g); ld_kind = 2'(k); ld_sel = 2'(s); ld_data = 14'(v);
        @(negedge clk);
        ld_en = 1'b0;
        case (k)
            0: begin m_ptr[g][s] = v & 16383; m_start[g][s] = v & 16383; end
            1: m_step[g][s] = (v & 8191) - (v & 8192);
            2: m_span[g][s] = v & 16383;
            default: ;
        endcase
    endtask

    task automatic access(int g, int p, int s, string tag);
        string t = (tag == "") ? auto_tag(g, p, s) : tag;
        acc_en[g] = 1'b1;
        acc_ptr[g*2 +: 2] = 2'(p);
        acc_mod[g*2 +: 2] = 2'(s);
        #1;
        chk(t, int'(addr[g*14 +: 14]), m_ptr[g][p]);
        chk("R2", int'(addr_vld[g]), 1);
        @(negedge clk);
        acc_en[g] = 1'b0;
        m_ptr[g][p] = model_next(g, p, s);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < 2; g++)
            for (int i = 0; i < 4; i++) begin
                m_ptr[g][i] = 0; m_step[g][i] = 0; m_span[g][i] = 0; m_start[g][i] = 0;
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R2 valid low when idle
        #1 chk("R2", int'(addr_vld), 0);
        for (int g = 0; g < 2; g++)
            for (int p = 0; p < 4; p++) access(g, p, p, "R1");

        // R3 linear wrap of the address space
        load(0, 1, 0, 1);
        load(0, 0, 0, 16383);
        access(0, 0, 0, "R3");
        access(0, 0, 0, "R3");

        // Sweep: every pointer against every step register, both units
        for (int g = 0; g < 2; g++) begin
            load(g, 1, 0, 1);
            load(g, 1, 1, -1);
            load(g, 1, 2, 3);
            load(g, 1, 3, -4);
            load(g, 2, 0, 0);
            load(g, 2, 1, 5);
            load(g, 2, 2, 7);
            load(g, 2, 3, 6);
            for (int p = 0; p < 4; p++) load(g, 0, p, 100 + 37 * p + 1000 * g);
            for (int p = 0; p < 4; p++)
                for (int s = 0; s < 4; s++)
                    for (int r = 0; r < 4; r++) access(g, p, s, "");
        end

        // R7 reload moves the window
        load(0, 0, 1, 500);
        for (int r = 0; r < 6; r++) access(0, 1, 2, "R7");

        // R8 load and access of the same pointer in one cycle
        ld_en = 1'b1; ld_gen = 1'b0; ld_kind = 2'd0; ld_sel = 2'd2; ld_data = 14'd800;
        acc_en[0] = 1'b1; acc_ptr[1:0] = 2'd2; acc_mod[1:0] = 2'd2;
        #1 chk("R8", int'(addr[13:0]), m_ptr[0][2]);
        @(negedge clk);
        ld_en = 1'b0; acc_en = '0;
        m_ptr[0][2] = 800; m_start[0][2] = 800;
        access(0, 2, 0, "R8");

        // R11 kind 3 writes nothing
        ld_en = 1'b1; ld_gen = 1'b0; ld_kind = 2'd3; ld_sel = 2'd2; ld_data = 14'd55;
        @(negedge clk);
        ld_en = 1'b0;
        access(0, 2, 0, "R11");
        access(0, 2, 0, "R11");

        // R10 idle cycles keep pointers
        repeat (5) @(negedge clk);
        for (int p = 0; p < 4; p++) access(1, p, 0, "R10");

        // R9 load to unit 1 while unit 0 steps, then both units at once
        load(1, 0, 3, 3000);
        ld_en = 1'b1; ld_gen = 1'b1; ld_kind = 2'd0; ld_sel = 2'd3; ld_data = 14'd4000;
        acc_en[0] = 1'b1; acc_ptr[1:0] = 2'd3; acc_mod[1:0] = 2'd0;
        #1 chk("R9", int'(addr[13:0]), m_ptr[0][3]);
        @(negedge clk);
        ld_en = 1'b0; acc_en = '0;
        m_ptr[0][3] = model_next(0, 3, 0);
        m_ptr[1][3] = 4000; m_start[1][3] = 4000;
        for (int r = 0; r < 3; r++) begin
            acc_en = 2'b11; acc_ptr = {2'd3, 2'd3}; acc_mod = {2'd2, 2'd1};
            #1;
            chk("R9", int'(addr[13:0]), m_ptr[0][3]);
            chk("R9", int'(addr[27:14]), m_ptr[1][3]);
            @(negedge clk);
            acc_en = '0;
            m_ptr[0][3] = model_next(0, 3, 1);
            m_ptr[1][3] = model_next(1, 3, 2);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule